// File: doc/BRIEF.md
# Register-mapped signed/unsigned multiply-divide unit

This block is an arithmetic unit that a processor reaches over a byte-wide register bus. Software loads a 32-bit dividend, a 16-bit multiplier and a 16-bit divisor one byte at a time. Writing the most significant byte of the multiplier runs a 16x16 multiply. Writing the most significant byte of the divisor runs a 32/16 divide. Both results are read back a byte at a time from a 32-bit result register and a 16-bit remainder register. A single flag bit selects two's-complement operation for both kinds of operation.

The multiply finishes in the cycle of the triggering write. The divide is a restoring divider that retires one quotient bit per clock, and status bit 7 stays high while it runs. While that bit is high, writes to the operand and flag registers are dropped. A zero divisor skips the iteration and returns a fixed result at once.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, every readable register (byte offsets 0x0 to 0xF) reads 0x00.
- R2: The byte offsets, least significant byte first, are: dividend 0x0-0x3, multiplier 0x4-0x5, divisor 0x6-0x7, result 0x8-0xB, remainder 0xC-0xD, flags 0xE, status 0xF. Operand bytes read back as written.
- R3: A write to offset 0x5 multiplies dividend bits [15:0] by the updated multiplier. With flag bit 0 clear the operands are unsigned. The 32-bit product can be read in the following cycle.
- R4: With flag bit 0 set, the multiply treats both 16-bit operands as two's complement and gives the sign-correct 32-bit product.
- R5: A write to offset 0x7 with a nonzero divisor starts a divide. With flag bit 0 clear it gives the unsigned 32-bit quotient and 16-bit remainder.
- R6: With flag bit 0 set, the divide treats the 32-bit dividend and the 16-bit divisor as two's complement. The quotient truncates toward zero and the remainder carries the sign of the dividend.
- R7: If the divisor is zero when offset 0x7 is written, the result becomes 0 and the remainder becomes dividend bits [15:0] in the following cycle, in both modes, and status bit 7 never rises.
- R8: A completed multiply sets status bit 0. The bit stays set until reset, and a divide does not change it.
- R9: From the cycle after a nonzero divide starts, status bit 7 reads 1. It returns to 0 within 34 cycles, once the quotient and remainder are readable.
- R10: While status bit 7 is 1, writes to offsets 0x0-0x7 and 0xE are ignored. A write to 0x5 or 0x7 starts nothing.
- R11: Only bit 0 of the flag register can be written. Writes to the result, remainder and status offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register byte offset |
| reg_we_i | input | 1 | Write strobe for the selected byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected byte, combinational |

## Verification
The bench builds the unit with its default widths: a 32-bit dividend and result, and 16-bit multiplier, divisor and remainder. This gives the full 32-iteration divide loop, from which the busy latency bound follows. It also brings in the extreme operands at those widths: a most-negative dividend divided by -1, a divisor of 0x8000 in signed mode, and all-ones unsigned operands. Random operands in both modes are checked against results computed in the bench with wide integer arithmetic, and directed runs cover zero divisors and writes issued while busy.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  localparam int unsigned DEF_DVD_W = 32;
  localparam int unsigned DEF_OPR_W = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned STS_BUSY  = 7;
  localparam int unsigned STS_MDONE = 0;
endpackage

// File: rtl/muldiv_mult.sv
`timescale 1ns/1ps
module muldiv_mult #(
  parameter int unsigned W = 16
) (
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  logic [2*W-1:0] a_ext, b_ext;

  // low 2W bits of the extended product are correct for either signedness
  always_comb begin
    a_ext = signed_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
    b_ext = signed_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
    p_o   = a_ext * b_ext;
  end
endmodule

// File: rtl/muldiv_div.sv
`timescale 1ns/1ps
module muldiv_div #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [SW-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    quo_q;
  logic [SW-1:0]    rem_q, dvs_q;
  logic             qneg_q, rneg_q, done_q;

  logic          dvd_neg, dvs_neg;
  logic [DW-1:0] dvd_mag;
  logic [SW-1:0] dvs_mag;
  logic [SW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    dvd_neg = signed_i & dividend_i[DW-1];
    dvs_neg = signed_i & divisor_i[SW-1];
    dvd_mag = dvd_neg ? -dividend_i : dividend_i;
    dvs_mag = dvs_neg ? -divisor_i : divisor_i;
    shifted = {rem_q, quo_q[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
  end

  assign busy_o = cnt_q != '0;
  assign done_o = done_q;
  assign quot_o = qneg_q ? -quo_q : quo_q;
  assign rem_o  = rneg_q ? -rem_q : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_o && (cnt_q == CNT_W'(1));
      if (start_i) begin
        cnt_q  <= CNT_W'(DW);
        quo_q  <= dvd_mag;
        rem_q  <= '0;
        dvs_q  <= dvs_mag;
        qneg_q <= dvd_neg ^ dvs_neg;
        rneg_q <= dvd_neg;
      end else if (busy_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
        quo_q <= {quo_q[DW-2:0], fits};
        rem_q <= fits ? diff[SW-1:0] : shifted[SW-1:0];
      end
    end
  end

  assert_start_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_rem_below_divisor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> rem_q < dvs_q);
  assert_finish_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == CNT_W'(1)) |=> (done_o && !busy_o));
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit #(
  parameter int unsigned DVD_W = muldiv_pkg::DEF_DVD_W,
  parameter int unsigned OPR_W = muldiv_pkg::DEF_OPR_W,
  localparam int unsigned DVD_B    = DVD_W / 8,
  localparam int unsigned OPR_B    = OPR_W / 8,
  localparam int unsigned DVD_BASE = 0,
  localparam int unsigned MUL_BASE = DVD_BASE + DVD_B,
  localparam int unsigned DVS_BASE = MUL_BASE + OPR_B,
  localparam int unsigned RES_BASE = DVS_BASE + OPR_B,
  localparam int unsigned REM_BASE = RES_BASE + DVD_B,
  localparam int unsigned FLG_ADDR = REM_BASE + OPR_B,
  localparam int unsigned STS_ADDR = FLG_ADDR + 1,
  localparam int unsigned ADDR_W   = $clog2(STS_ADDR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);
  import muldiv_pkg::*;

  logic [DVD_W-1:0] dvd_q, dvd_d, res_q, prod, quot;
  logic [OPR_W-1:0] mul_q, mul_d, dvs_q, dvs_d, rem_q, rem_div;
  logic             sgn_q, mdone_q, busy_q;
  logic             wr_ok, mul_go, div_go, dvz, div_start, div_busy, div_done;

  always_comb begin
    wr_ok = reg_we_i && !busy_q;
    dvd_d = dvd_q;
    mul_d = mul_q;
    dvs_d = dvs_q;
    for (int b = 0; b < DVD_B; b++)
      if (wr_ok && reg_addr_i == ADDR_W'(DVD_BASE + b)) dvd_d[8*b +: 8] = reg_wdata_i;
    for (int b = 0; b < OPR_B; b++) begin
      if (wr_ok && reg_addr_i == ADDR_W'(MUL_BASE + b)) mul_d[8*b +: 8] = reg_wdata_i;
      if (wr_ok && reg_addr_i == ADDR_W'(DVS_BASE + b)) dvs_d[8*b +: 8] = reg_wdata_i;
    end
    // top operand byte triggers the operation
    mul_go    = wr_ok && reg_addr_i == ADDR_W'(MUL_BASE + OPR_B - 1);
    div_go    = wr_ok && reg_addr_i == ADDR_W'(DVS_BASE + OPR_B - 1);
    dvz       = div_go && (dvs_d == '0);
    div_start = div_go && !dvz;
  end

  muldiv_mult #(.W(OPR_W)) i_mult (
    .signed_i (sgn_q),
    .a_i      (dvd_q[OPR_W-1:0]),
    .b_i      (mul_d),
    .p_o      (prod)
  );

  muldiv_div #(.DW(DVD_W), .SW(OPR_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .signed_i   (sgn_q),
    .dividend_i (dvd_q),
    .divisor_i  (dvs_d),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (quot),
    .rem_o      (rem_div)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q   <= '0;
      mul_q   <= '0;
      dvs_q   <= '0;
      res_q   <= '0;
      rem_q   <= '0;
      sgn_q   <= 1'b0;
      mdone_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      dvd_q <= dvd_d;
      mul_q <= mul_d;
      dvs_q <= dvs_d;
      if (wr_ok && reg_addr_i == ADDR_W'(FLG_ADDR)) sgn_q <= reg_wdata_i[0];
      if (mul_go) begin
        res_q   <= prod;
        mdone_q <= 1'b1;
      end
      if (dvz) begin
        res_q <= '0;
        rem_q <= dvd_q[OPR_W-1:0];
      end
      if (div_start) busy_q <= 1'b1;
      if (div_done) begin
        res_q  <= quot;
        rem_q  <= rem_div;
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < DVD_B; b++) begin
      if (reg_addr_i == ADDR_W'(DVD_BASE + b)) reg_rdata_o = dvd_q[8*b +: 8];
      if (reg_addr_i == ADDR_W'(RES_BASE + b)) reg_rdata_o = res_q[8*b +: 8];
    end
    for (int b = 0; b < OPR_B; b++) begin
      if (reg_addr_i == ADDR_W'(MUL_BASE + b)) reg_rdata_o = mul_q[8*b +: 8];
      if (reg_addr_i == ADDR_W'(DVS_BASE + b)) reg_rdata_o = dvs_q[8*b +: 8];
      if (reg_addr_i == ADDR_W'(REM_BASE + b)) reg_rdata_o = rem_q[8*b +: 8];
    end
    if (reg_addr_i == ADDR_W'(FLG_ADDR)) reg_rdata_o = {7'b0, sgn_q};
    if (reg_addr_i == ADDR_W'(STS_ADDR)) begin
      reg_rdata_o[STS_BUSY]  = busy_q;
      reg_rdata_o[STS_MDONE] = mdone_q;
    end
  end

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && reg_we_i) |=> ($stable(dvd_q) && $stable(mul_q) && $stable(dvs_q) && $stable(sgn_q)));
  assert_busy_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(DVS_BASE + OPR_B - 1)));
  assert_busy_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |=> !busy_q);
  assert_div_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvz |=> (res_q == '0 && rem_q == $past(dvd_q[OPR_W-1:0]) && !busy_q));
  assert_mdone_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdone_q |=> mdone_q);
endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(base + 4'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic rd16(input logic [3:0] base, output logic [15:0] v);
    logic [7:0] b;
    rd(base, b);      v[7:0]  = b;
    rd(base + 4'd1, b); v[15:8] = b;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] exp_mul(logic [15:0] a, logic [15:0] b, bit s);
    longint p;
    if (s) p = longint'($signed(a)) * longint'($signed(b));
    else   p = longint'({16'b0, a}) * longint'({16'b0, b});
    return p[31:0];
  endfunction

  function automatic logic [47:0] exp_div(logic [31:0] n, logic [15:0] d, bit s);
    longint a, b, q, r;
    if (d == 16'h0) return {32'h0, n[15:0]};
    if (s) begin a = longint'($signed(n)); b = longint'($signed(d)); end
    else   begin a = longint'({32'b0, n}); b = longint'({48'b0, d}); end
    q = a / b;
    r = a % b;
    return {q[31:0], r[15:0]};
  endfunction

  task automatic load(input logic [31:0] n);
    for (int i = 0; i < 4; i++) wr(4'(i), n[8*i +: 8]);
  endtask

  task automatic run_mul(input string req, input logic [15:0] a, input logic [15:0] b, input bit s);
    logic [31:0] r;
    wr(4'hE, {7'b0, s});
    load({16'h0, a});
    wr(4'h4, b[7:0]);
    wr(4'h5, b[15:8]);
    rd32(4'h8, r);
    chk(req, r, exp_mul(a, b, s));
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] st;
    n = 0;
    rd(4'hF, st);
    while (st[7] && n < 60) begin
      n++;
      rd(4'hF, st);
    end
  endtask

  task automatic run_div(input string req, input logic [31:0] n, input logic [15:0] d, input bit s);
    logic [31:0] q; logic [15:0] r; logic [47:0] e; int cyc;
    wr(4'hE, {7'b0, s});
    load(n);
    wr(4'h6, d[7:0]);
    wr(4'h7, d[15:8]);
    wait_idle(cyc);
    rd32(4'h8, q);
    rd16(4'hC, r);
    e = exp_div(n, d, s);
    chk({req, " quotient"}, q, e[47:16]);
    chk({req, " remainder"}, {16'h0, r}, {16'h0, e[15:0]});
  endtask

  initial begin
    logic [7:0] b8; logic [31:0] v32; logic [15:0] v16; int cyc;
    void'($urandom(32'd7021));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b8);
      chk("R1 reset value", {24'h0, b8}, 32'h0);
    end

    // R2 readback of operand bytes
    load(32'hA1B2C3D4);
    wr(4'h4, 8'h5E);
    wr(4'h6, 8'h6F);
    rd32(4'h0, v32);
    chk("R2 dividend readback", v32, 32'hA1B2C3D4);
    rd(4'h4, b8); chk("R2 multiplier low readback", {24'h0, b8}, 32'h5E);
    rd(4'h6, b8); chk("R2 divisor low readback", {24'h0, b8}, 32'h6F);

    // R11 write-protected bits and registers
    wr(4'hE, 8'hFE);
    rd(4'hE, b8); chk("R11 flag upper bits", {24'h0, b8}, 32'h0);
    wr(4'hE, 8'hFF);
    rd(4'hE, b8); chk("R11 flag bit0", {24'h0, b8}, 32'h1);
    wr(4'h8, 8'h77); wr(4'hC, 8'h77); wr(4'hF, 8'hFF);
    rd32(4'h8, v32); chk("R11 result write ignored", v32, 32'h0);
    rd16(4'hC, v16); chk("R11 remainder write ignored", {16'h0, v16}, 32'h0);
    rd(4'hF, b8);    chk("R11 status write ignored", {24'h0, b8}, 32'h0);

    // R3 / R4 multiply
    run_mul("R3 unsigned mul max", 16'hFFFF, 16'hFFFF, 1'b0);
    run_mul("R3 unsigned mul", 16'd1234, 16'd5678, 1'b0);
    rd(4'hF, b8); chk("R8 status bit0 after mul", {31'h0, b8[0]}, 32'h1);
    run_mul("R4 signed mul neg*pos", 16'hFFF9, 16'd300, 1'b1);
    run_mul("R4 signed mul min*min", 16'h8000, 16'h8000, 1'b1);
    run_mul("R4 signed mul min*max", 16'h8000, 16'h7FFF, 1'b1);
    for (int i = 0; i < 40; i++)
      run_mul(i[0] ? "R4 random signed mul" : "R3 random unsigned mul",
              16'($urandom), 16'($urandom), i[0]);

    // R5 / R6 divide
    run_div("R5 unsigned div max", 32'hFFFFFFFF, 16'hFFFF, 1'b0);
    run_div("R5 unsigned div by 1", 32'hDEADBEEF, 16'h0001, 1'b0);
    rd(4'hF, b8); chk("R8 bit0 kept by divide", {31'h0, b8[0]}, 32'h1);
    run_div("R6 signed -7/2", 32'hFFFFFFF9, 16'h0002, 1'b1);
    run_div("R6 signed 7/-2", 32'h00000007, 16'hFFFE, 1'b1);
    run_div("R6 signed min/-1", 32'h80000000, 16'hFFFF, 1'b1);
    run_div("R6 signed by 0x8000", 32'h12345678, 16'h8000, 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      d = (i % 3 == 0) ? 16'($urandom % 9 + 1) : 16'($urandom);
      if (d == 16'h0) d = 16'h3;
      run_div(i[0] ? "R6 random signed div" : "R5 random unsigned div", $urandom, d, i[0]);
    end

    // R7 divide by zero, both modes, result visible next cycle
    run_div("R7 div by zero unsigned", 32'h1234ABCD, 16'h0000, 1'b0);
    run_div("R7 div by zero signed", 32'hF00D8765, 16'h0000, 1'b1);
    rd(4'hF, b8); chk("R7 no busy on zero divisor", {31'h0, b8[7]}, 32'h0);

    // R9 / R10 busy window and ignored writes, from a fresh reset
    do_reset();
    load(32'd1000000);
    wr(4'h6, 8'd7);
    wr(4'h7, 8'h00);
    rd(4'hF, b8); chk("R9 busy after start", {31'h0, b8[7]}, 32'h1);
    wr(4'h0, 8'hAA);
    wr(4'h4, 8'h03);
    wr(4'h5, 8'h12);
    wr(4'h6, 8'h55);
    wr(4'hE, 8'h01);
    wait_idle(cyc);
    chk("R9 busy ends within 34 cycles", {31'h0, cyc <= 33}, 32'h1);
    rd32(4'h8, v32); chk("R10 quotient of original operands", v32, 32'd142857);
    rd16(4'hC, v16); chk("R10 remainder of original operands", {16'h0, v16}, 32'd1);
    rd32(4'h0, v32); chk("R10 dividend write ignored", v32, 32'd1000000);
    rd16(4'h4, v16); chk("R10 multiplier write ignored", {16'h0, v16}, 32'h0);
    rd(4'h6, b8);    chk("R10 divisor write ignored", {24'h0, b8}, 32'd7);
    rd(4'hE, b8);    chk("R10 flag write ignored", {24'h0, b8}, 32'h0);
    rd(4'hF, b8);    chk("R10 no multiply during busy", {24'h0, b8}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule